// File: doc/BRIEF.md
# Base-Two Approximate Softmax Unit

This unit turns a vector of N signed 8-bit class scores into N probability-like results. It uses 2 rather than e as the base, so each result approximates 2^xi divided by the sum of 2^xk over every class. Each score is read as the exponent of a floating-point number whose mantissa is exactly 1.0. A binary tree of floating-point adders forms the sum. A two-segment piecewise-linear approximation then takes the reciprocal of the sum's mantissa. Finally, one integer subtractor per class produces that class's result exponent.

All classes share the same reciprocal mantissa, so only the exponents differ between results. The scores are captured when `in_valid` is high. The full vector of results appears together, with `out_valid` high, a fixed two cycles later. N is a power of two from 2 to 64.

Top module: `base2_softmax`

## Requirements
- R1: Score i is the signed 8-bit field `x_flat[8i+7:8i]` in the range -128..127. The adder tree treats it as the floating-point value 2^xi with mantissa 1.0.
- R2: Result i is the 17-bit field `p_flat[17i+16:17i]`. Bits [16:8] hold a 9-bit two's-complement unbiased exponent E and bits [7:0] hold a fraction F. The value is 2^E·(1+F/256). There is no sign bit and no encoding for zero.
- R3: E equals xi minus the sum exponent, minus 1 when the reciprocal is below 1.0. No result exponent is above 0.
- R4: The sum mantissa is X = 1.f, held as a 9-bit value in units of 2^-8. The reciprocal y, also in units of 2^-8, is computed by truncating shifts. When fraction bit f[7] is 0, y = 408 - (X>>1) - (X>>3). When f[7] is 1, y = 288 - (X>>2) - (X>>4). If y < 256, y is doubled so that its leading 1 becomes implicit, and F = (2y) mod 256.
- R5: Every result carries the same fraction F.
- R6: The tree adds adjacent pairs (0,1), (2,3) and so on, level by level. Each adder keeps the larger exponent and shifts the smaller 9-bit mantissa right by the exponent difference, truncating. A difference of 9 or more flushes the smaller mantissa to zero. A mantissa carry increments the exponent and truncates the mantissa by one bit.
- R7: Every result whose exponent is not clamped lies within 5% of the exact 2^xi/Σ2^xk. The N results sum to 1 within 5%.
- R8: An exponent that would fall below -256 is clamped to -256.
- R9: `out_valid` rises exactly two clock edges after an edge that samples `in_valid` high.
- R10: The results hold their value while no new valid vector is completing.
- R11: Reset (active low) clears `out_valid` and all results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Score vector is valid |
| x_flat | input | 8·N | Packed signed scores |
| out_valid | output | 1 | Result vector is valid |
| p_flat | output | 17·N | Packed floating-point results |

## Verification
Equal scores make every first-level add carry, which exercises the carry path and the reciprocal at X = 1.0 (F = 240). Pairs such as {3,3,4,4} give a sum mantissa of 1.5, which selects the second segment (F = 80). Inputs {10,0,0,0} and {8,0,0,0} separate a flushed operand from a truncated single-LSB contribution (F = 240 against F = 238). A vector of three 127s and one -128 drives the clamp. A sweep over every combination of eight spread-out score values then checks the accuracy of each result and of their total against the exact base-two ratio.

// File: rtl/base2_softmax.sv
module base2_softmax #(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N*8-1:0]   x_flat,
  output logic             out_valid,
  output logic [N*17-1:0]  p_flat
);
  // Latency from in_valid to out_valid: input register plus output register.
  localparam int LATENCY = 2;
  localparam int OW = 17;

  if (N < 2 || N > 64 || (N & (N - 1)) != 0) begin : g_bad_n
    $error("N must be a power of two in 2..64");
  end

  logic [N*8-1:0] xr;
  logic           v1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xr <= '0;
      v1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) xr <= x_flat;
    end

  function automatic logic [18:0] fadd(input logic signed [9:0] ea, input logic [8:0] ma,
                                       input logic signed [9:0] eb, input logic [8:0] mb);
    logic signed [9:0] eh, el;
    logic [8:0] mh, ml;
    logic [9:0] d, s;
    if (ea >= eb) begin
      eh = ea; mh = ma; el = eb; ml = mb;
    end else begin
      eh = eb; mh = mb; el = ea; ml = ma;
    end
    d = eh - el;
    s = {1'b0, mh} + ((d >= 10'd9) ? 10'd0 : {1'b0, ml >> d});
    if (s[9]) fadd = {eh + 10'sd1, s[9:1]};
    else      fadd = {eh, s[8:0]};
  endfunction

  logic signed [9:0] ne [1:2*N-1];
  logic        [8:0] nm [1:2*N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign ne[N+i] = {{2{xr[i*8+7]}}, xr[i*8+:8]};
    assign nm[N+i] = 9'h100;
  end

  for (genvar k = 1; k < N; k++) begin : g_tree
    assign {ne[k], nm[k]} = fadd(ne[2*k], nm[2*k], ne[2*k+1], nm[2*k+1]);
  end

  logic [8:0] y;
  logic       nrm;
  logic [7:0] frac;

  assign y    = nm[1][7] ? (9'd288 - (nm[1] >> 2) - (nm[1] >> 4))
                         : (9'd408 - (nm[1] >> 1) - (nm[1] >> 3));
  assign nrm  = ~y[8];
  assign frac = y[8] ? y[7:0] : {y[6:0], 1'b0};

  logic [N*OW-1:0] pn;

  for (genvar i = 0; i < N; i++) begin : g_sub
    logic signed [10:0] oe;
    assign oe = {{3{xr[i*8+7]}}, xr[i*8+:8]} - {ne[1][9], ne[1]} - {10'd0, nrm};
    assign pn[i*OW+:OW] = {(oe < -11'sd256) ? 9'h100 : oe[8:0], frac};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      p_flat    <= '0;
    end else begin
      out_valid <= v1;
      if (v1) p_flat <= pn;
    end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(p_flat));

  assert_recip_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> (y >= 9'd128 && y <= 9'd248));

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_sum_dominates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      v1 |-> ne[1] >= ne[N+i]);
    assert_exp_nonpos_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $signed(p_flat[i*OW+8+:9]) <= 0);
    assert_shared_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> p_flat[i*OW+:8] == p_flat[7:0]);
  end

  initial assert (LATENCY == 2);
endmodule

// File: tb/tb_base2_softmax.sv
module tb_base2_softmax;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [N*8-1:0] x_flat = '0;
  logic out_valid;
  logic [N*17-1:0] p_flat;
  int total = 0, passed = 0;
  bit done = 0;

  base2_softmax #(.N(N)) dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_flat(x_flat), .out_valid(out_valid), .p_flat(p_flat));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string msg);
    total++;
    if (ok) passed++;
    else $display("FAIL %s", msg);
  endtask

  function automatic int fexp(input int i);
    logic [8:0] e;
    e = p_flat[i*17+8+:9];
    return $signed(e);
  endfunction

  task automatic apply(input int a, input int b, input int c, input int d);
    int v[N];
    v = '{a, b, c, d};
    @(negedge clk);
    for (int i = 0; i < N; i++) x_flat[i*8+:8] = 8'(v[i]);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0, $sformatf("R9 early valid got %0d exp 0", out_valid));
    @(negedge clk);
    chk(out_valid == 1, $sformatf("R9 valid got %0d exp 1", out_valid));
  endtask

  task automatic exact(input int i, input int e, input int f, input string req);
    chk(fexp(i) == e && p_flat[i*17+:8] == 8'(f),
        $sformatf("%s out%0d got e=%0d f=%0d exp e=%0d f=%0d", req, i, fexp(i),
                  p_flat[i*17+:8], e, f));
  endtask

  task automatic tol(input int a, input int b, input int c, input int d);
    int v[N];
    real den, ev, got, sum;
    int mx;
    v = '{a, b, c, d};
    mx = v[0];
    for (int i = 1; i < N; i++) if (v[i] > mx) mx = v[i];
    den = 0.0;
    for (int i = 0; i < N; i++) den += 2.0 ** (v[i] - mx);
    sum = 0.0;
    for (int i = 0; i < N; i++) begin
      ev  = (2.0 ** (v[i] - mx)) / den;
      got = (1.0 + p_flat[i*17+:8] / 256.0) * (2.0 ** fexp(i));
      sum += got;
      if (fexp(i) == -256)
        chk(ev < 2.0 ** -250, $sformatf("R8 clamp out%0d got %g exp %g", i, got, ev));
      else
        chk(got / ev - 1.0 <= 0.05 && got / ev - 1.0 >= -0.05,
            $sformatf("R7 out%0d in %0d,%0d,%0d,%0d got %g exp %g", i, a, b, c, d, got, ev));
    end
    chk(sum >= 0.95 && sum <= 1.05, $sformatf("R7 sum got %g exp 1.0", sum));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      $display("FAIL watchdog R9 got timeout exp completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    int vals[8];
    logic [N*17-1:0] held;
    vals = '{-128, -40, -9, -1, 0, 2, 6, 127};
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && p_flat == '0, $sformatf("R11 reset got v=%0d p=%h exp 0", out_valid, p_flat));
    rst_n = 1;

    apply(5, 5, 5, 5);        // R4 X=1.0, R6 carry, R5 shared
    for (int i = 0; i < N; i++) exact(i, -3, 240, "R4 R5 R6 equal");
    apply(-128, -128, -128, -128);
    for (int i = 0; i < N; i++) exact(i, -3, 240, "R1 R3 low equal");
    apply(3, 3, 4, 4);        // R4 second segment
    exact(0, -3, 80, "R4"); exact(1, -3, 80, "R4");
    exact(2, -2, 80, "R3"); exact(3, -2, 80, "R3");
    apply(10, 0, 0, 0);       // R6 flush
    exact(0, -1, 240, "R6 flush");
    for (int i = 1; i < N; i++) exact(i, -11, 240, "R6 flush");
    apply(8, 0, 0, 0);        // R6 truncated alignment
    exact(0, -1, 238, "R6 trunc");
    for (int i = 1; i < N; i++) exact(i, -9, 238, "R6 trunc");
    apply(127, 127, 127, -128);
    for (int i = 0; i < 3; i++) exact(i, -2, 80, "R2 R3");
    exact(3, -256, 80, "R8 clamp");

    held = p_flat;
    @(negedge clk);
    x_flat = {4{8'h11}};
    repeat (3) @(negedge clk);
    chk(p_flat == held && out_valid == 0, $sformatf("R10 hold got %h exp %h", p_flat, held));

    foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[d]) begin
      apply(vals[a], vals[b], vals[c], vals[d]);
      tol(vals[a], vals[b], vals[c], vals[d]);
    end

    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule